// File: doc/BRIEF.md
# Read-Sequenced Security Responder

This block stands behind two byte-wide read ports of a bus peripheral and answers a protection check. The first port returns an external input word in which two bits are replaced by a pattern. A three-bit counter that steps on every read of that port picks the pattern, so successive reads return a fixed sequence. The second port holds a byte written by the host. Reads of that port do not return the byte itself. They return a fixed nonlinear logic function of it.

The host uses single-cycle read and write strobes and a two-bit port select. Read data is registered. It appears one clock after the read strobe and holds until the next read strobe. The port select codes are: 2'b00 selects the sequenced input port, 2'b01 selects the protection port, and 2'b10 and 2'b11 are unmapped.

Top module: `sec_responder`

## Requirements
- R1: After reset, `rd_data` is 0x00, the sequence counter is 0 and the protection latch is 0x00.
- R2: The read result appears on `rd_data` at the first clock edge after the cycle in which `rd_stb` is high. It holds unchanged in every cycle without a read strobe.
- R3: A read with `port_sel`=2'b00 replaces bits 7 and 5 of `ext_in` using the counter value before the read. Counts 0 and 1 give bit7=0 and bit5=1. Count 2 gives bit7=1 and bit5=0. Counts 3 to 7 give bit7=1 and bit5=1.
- R4: On a read with `port_sel`=2'b00, bits 6, 4, 3, 2, 1 and 0 equal those of `ext_in` in the strobe cycle.
- R5: The counter advances by exactly one per read strobe with `port_sel`=2'b00 and wraps from 7 to 0. Reads with any other select, and cycles without a read, leave it unchanged.
- R6: A write strobe with `port_sel`=2'b01 stores `wr_data` in the protection latch. Write strobes with any other select leave the latch unchanged.
- R7: A read with `port_sel`=2'b01 returns latch bits 3..0 in bits 3..0. Bit 4 is the NOR of latch bits 0 to 3.
- R8: Protection read bit 5 is 1 when latch bits 2 and 3 are both set, or when latch bits 0 and 1 are both set. Otherwise it is 0.
- R9: Protection read bit 6 is latch bit0 OR bit3. Bit 7 is latch bit1 AND NOT bit2.
- R10: A read with `port_sel` of 2'b10 or 2'b11 returns 0x00.
- R11: When a read and a write of the protection port fall in the same cycle, the read returns the function of the latch value from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| rd_stb | input | 1 | Single-cycle read strobe |
| wr_stb | input | 1 | Single-cycle write strobe |
| port_sel | input | 2 | Port select: 00 sequenced input, 01 protection, 10/11 unmapped |
| wr_data | input | 8 | Write data |
| ext_in | input | 8 | External input word |
| rd_data | output | 8 | Registered read data |

## Verification
Every read result is due exactly one clock edge after its strobe cycle. The bench therefore drives the strobe on a falling edge, removes it on the next falling edge, and samples `rd_data` there. The register has updated once at the rising edge between those two falling edges. Latch and counter updates take effect at the same edge, so a write is followed by a protection read one cycle later. A counter step shows up in the overlay of the next sequenced read. The bench sweeps all 256 latch values and a run of several full counter periods. Between reads it inserts unmapped reads, protection reads and stray writes, then checks that the predicted pattern continues unbroken.

// File: rtl/sec_responder.sv
module sec_responder (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rd_stb,
  input  logic       wr_stb,
  input  logic [1:0] port_sel,
  input  logic [7:0] wr_data,
  input  logic [7:0] ext_in,
  output logic [7:0] rd_data
);

  localparam logic [1:0] SEL_SEQ  = 2'b00;
  localparam logic [1:0] SEL_PROT = 2'b01;

  logic [2:0] seq_cnt;
  logic [7:0] prot_q;
  logic [7:0] seq_word;
  logic [7:0] prot_word;
  logic [1:0] pat;
  logic       rd_seq, rd_prot, wr_prot;

  assign rd_seq  = rd_stb && port_sel == SEL_SEQ;
  assign rd_prot = rd_stb && port_sel == SEL_PROT;
  assign wr_prot = wr_stb && port_sel == SEL_PROT;

  // pat = {bit7, bit5}
  always_comb begin
    case (seq_cnt)
      3'd0, 3'd1: pat = 2'b01;
      3'd2:       pat = 2'b10;
      default:    pat = 2'b11;
    endcase
  end

  assign seq_word = {pat[1], ext_in[6], pat[0], ext_in[4:0]};

  logic [3:0] b;
  assign b = prot_q[3:0];
  assign prot_word[3:0] = b;
  assign prot_word[4]   = ~(b[0] | b[1] | b[2] | b[3]);
  assign prot_word[5]   = ~((~b[2] & ~b[0]) | (~b[2] & ~b[1]) |
                            (~b[3] & ~b[0]) | (~b[3] & ~b[1]));
  assign prot_word[6]   = b[0] | b[3];
  assign prot_word[7]   = b[1] & ~b[2];

  always_ff @(posedge clk) begin
    if (!rst_n)       seq_cnt <= '0;
    else if (rd_seq)  seq_cnt <= seq_cnt + 3'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       prot_q <= '0;
    else if (wr_prot) prot_q <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       rd_data <= '0;
    else if (rd_stb) begin
      if (rd_seq)       rd_data <= seq_word;
      else if (rd_prot) rd_data <= prot_word;
      else              rd_data <= '0;
    end
  end

  a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
    rd_seq |=> seq_cnt == $past(seq_cnt) + 3'd1);
  a_r5_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_seq |=> $stable(seq_cnt));
  a_r6_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_prot |=> $stable(prot_q));
  a_r2_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(rd_data));
  a_r4_passthru: assert property (@(posedge clk) disable iff (!rst_n)
    rd_seq |=> (rd_data & 8'h5F) == ($past(ext_in) & 8'h5F));
  a_r7_low_nibble: assert property (@(posedge clk) disable iff (!rst_n)
    rd_prot |=> rd_data[3:0] == $past(prot_q[3:0]));
  a_r10_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && port_sel[1]) |=> rd_data == 8'h00);

endmodule

// File: tb/test_sec_responder.sv
module test_sec_responder;
  localparam int CLK_PERIOD = 10;

  logic       clk = 0;
  logic       rst_n = 0;
  logic       rd_stb = 0, wr_stb = 0;
  logic [1:0] port_sel = 0;
  logic [7:0] wr_data = 0, ext_in = 0;
  logic [7:0] rd_data;

  int checks = 0, errors = 0;
  int exp_cnt = 0;
  logic [7:0] exp_latch = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sec_responder i_sec_responder (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .port_sel(port_sel), .wr_data(wr_data), .ext_in(ext_in), .rd_data(rd_data)
  );

  function automatic logic [7:0] prot_fn(input logic [7:0] v);
    logic [7:0] r;
    r[3:0] = v[3:0];
    r[4] = (v[3:0] == 4'd0);
    r[5] = (v[2] & v[3]) | (v[0] & v[1]);
    r[6] = v[0] | v[3];
    r[7] = v[1] & ~v[2];
    return r;
  endfunction

  function automatic logic [7:0] seq_fn(input logic [7:0] e, input int c);
    logic [7:0] r;
    r = e;
    r[7] = (c >= 2);
    r[5] = (c != 2);
    return r;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [1:0] s, input logic [7:0] e);
    @(negedge clk);
    rd_stb = 1; port_sel = s; ext_in = e;
    @(negedge clk);
    rd_stb = 0;
  endtask

  task automatic do_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1; port_sel = s; wr_data = d;
    @(negedge clk);
    wr_stb = 0;
  endtask

  task automatic seq_read(input logic [7:0] e, input string req);
    do_read(2'b00, e);
    chk(req, rd_data, seq_fn(e, exp_cnt));
    exp_cnt = (exp_cnt + 1) % 8;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 rd_data reset", rd_data, 8'h00);
    do_read(2'b01, 8'h00);
    chk("R1 latch reset", rd_data, prot_fn(8'h00));
    seq_read(8'hFF, "R1 counter reset");

    // R3/R4: several counter periods, varied input words
    for (int i = 0; i < 40; i++) seq_read(8'(i * 37 + 5), "R3 R4 overlay");

    // R2 hold: change input without strobe
    seq_read(8'h00, "R2 registered read");
    begin
      logic [7:0] held;
      held = rd_data;
      ext_in = 8'hFF;
      repeat (4) @(negedge clk);
      chk("R2 hold without strobe", rd_data, held);
    end

    // R5: other-port reads do not advance counter
    for (int i = 0; i < 10; i++) begin
      do_read(2'b01, 8'hAA);
      do_read(2'(2 + (i % 2)), 8'h55);
      chk("R10 unmapped read", rd_data, 8'h00);
      repeat (i % 3) @(negedge clk);
      seq_read(8'h5A ^ 8'(i), "R5 counter skips other ports");
    end

    // R6/R7/R8/R9: exhaustive latch sweep
    for (int v = 0; v < 256; v++) begin
      do_write(2'b01, 8'(v));
      exp_latch = 8'(v);
      do_read(2'b01, 8'h00);
      chk("R7 R8 R9 protection function", rd_data, prot_fn(exp_latch));
    end

    // R6: writes on other selects ignored
    do_write(2'b01, 8'h3C);
    exp_latch = 8'h3C;
    for (int s = 0; s < 4; s++) begin
      if (s == 1) continue;
      do_write(2'(s), 8'hC3);
      do_read(2'b01, 8'h00);
      chk("R6 foreign write ignored", rd_data, prot_fn(exp_latch));
    end
    seq_read(8'h11, "R6 write leaves counter");

    // R11: simultaneous read and write of protection port
    @(negedge clk);
    rd_stb = 1; wr_stb = 1; port_sel = 2'b01; wr_data = 8'h0B;
    @(negedge clk);
    rd_stb = 0; wr_stb = 0;
    chk("R11 read sees old latch", rd_data, prot_fn(8'h3C));
    do_read(2'b01, 8'h00);
    chk("R11 write took effect", rd_data, prot_fn(8'h0B));

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    exp_cnt = 0;
    chk("R1 rd_data after reset", rd_data, 8'h00);
    seq_read(8'h00, "R1 counter after reset");
    do_read(2'b01, 8'h00);
    chk("R1 latch after reset", rd_data, prot_fn(8'h00));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule